// File: doc/BRIEF.md
# Line-State Write Dispatcher

This block sits behind the data-cache directory lookup and decides what a processor write does, based on the state of the slot it hit. A coherent line is written through: the cache copy is updated and the write also goes to the write buffer. A non-coherent line is written back: only the cache copy changes, and the line and the written word are marked dirty. A write to a line that has been evicted but whose cleanup is not yet acknowledged gets no response, so the processor retries it. This keeps the new data from overtaking the older cleanup data at the next level, where that data would overwrite it. A miss, or any uncacheable write, goes only to the write buffer.

The block keeps three kinds of per-line state. The first is a dirty flag for each line. The second is a dirty bit for each word. The third is a flag that marks a zombie line as having left the non-coherent state. The caller reports two events: the eviction of a dirty non-coherent line, and the cleanup acknowledge for a line. Four 32-bit counters record write-backs, cacheable write misses, writes stalled on zombie lines, and the subset of those stalls whose zombie line came from the non-coherent state.

Top module: `write_dispatch`

## Requirements
- R1: Slot states are encoded EMPTY=0, coherent=1, non-coherent=2, zombie=3. In the same cycle, a cacheable write to a coherent slot raises rsp_valid, wbuf_post and cache_update.
- R2: In the same cycle, a cacheable write to a non-coherent slot raises rsp_valid and cache_update without wbuf_post. From the next cycle, that line is dirty and the addressed word's dirty bit is set, and cnt_write_back has grown by one.
- R3: A write of any kind to a zombie slot raises retry, and leaves rsp_valid, wbuf_post and cache_update low.
- R4: Each write stalled on a zombie slot adds one to cnt_zombie. It also adds one to cnt_zombie_ncc when that line's non-coherent-zombie flag is set.
- R5: A write to an EMPTY slot, or any uncacheable write to a non-zombie slot, raises rsp_valid and wbuf_post without cache_update and changes no dirty state. Only a cacheable write to an EMPTY slot adds one to cnt_write_miss.
- R6: An eviction clears that line's dirty flag and all its word dirty bits, and sets its non-coherent-zombie flag. Lines are indexed way*SETS+set, so other ways of the same set are not touched.
- R7: A cleanup acknowledge clears the line's non-coherent-zombie flag. A write to the same line in the same cycle sees the slot as EMPTY.
- R8: wbuf_post and cache_update are only high together with rsp_valid, and nothing is raised without wr_valid. Counters change one clock edge after the event.
- R9: After reset, all dirty state, all flags and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_cacheable | input | 1 | Write targets cacheable space |
| wr_way | input | WAY_W | Way of the looked-up slot |
| wr_set | input | SET_W | Set of the write |
| wr_word | input | WORD_W | Word within the line |
| slot_state | input | 2 | Looked-up slot state (R1 encoding) |
| evict_valid | input | 1 | Dirty non-coherent line evicted with cleanup data |
| evict_way | input | WAY_W | Way of the evicted line |
| evict_set | input | SET_W | Set of the evicted line |
| ack_valid | input | 1 | Cleanup acknowledge |
| ack_way | input | WAY_W | Way of the acknowledged line |
| ack_set | input | SET_W | Set of the acknowledged line |
| wbuf_post | output | 1 | Post write to write buffer |
| cache_update | output | 1 | Update cache data |
| rsp_valid | output | 1 | Processor response |
| retry | output | 1 | Write stalled; retry |
| line_dirty | output | 1 | Dirty flag of the line at wr_way/wr_set |
| word_dirty | output | 1 | Dirty bit of the word at wr_way/wr_set/wr_word |
| cnt_write_back | output | 32 | Non-coherent write count |
| cnt_write_miss | output | 32 | Cacheable miss count |
| cnt_zombie | output | 32 | Writes stalled on zombie lines |
| cnt_zombie_ncc | output | 32 | Stalls on zombie lines from the non-coherent state |

## Verification
A cleanup acknowledge and a write can both target the same line in the same cycle. The bench provokes this by evicting a line, stalling a write on it, and then giving the acknowledge and the zombie-state write to that line together. It judges the result by a miss-style response with a write-buffer post and no retry, by cnt_write_miss rising while both zombie counters hold, and by a later zombie write to the same line no longer adding to cnt_zombie_ncc. A second case gives the acknowledge to a different way of the same set during a zombie write, and expects the write to stay stalled.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY  = 2'd0,
    SLOT_COH    = 2'd1,
    SLOT_NONCOH = 2'd2,
    SLOT_ZOMBIE = 2'd3
  } slot_e;

  localparam int CNT_W   = 32;
  localparam int EV_WB   = 0;
  localparam int EV_MISS = 1;
  localparam int EV_ZOMB = 2;
  localparam int EV_ZNCC = 3;
  localparam int EV_N    = 4;

  function automatic int line_index(input int way, input int set, input int sets);
    return way * sets + set;
  endfunction

  function automatic int bit_index(input int line, input int word, input int words);
    return line * words + word;
  endfunction
endpackage

// File: rtl/wd_decide.sv
module wd_decide
  import wd_pkg::*;
(
  input  logic  req,
  input  logic  cacheable,
  input  slot_e state,
  output logic  post,
  output logic  update,
  output logic  respond,
  output logic  stall,
  output logic  ev_wb,
  output logic  ev_miss,
  output logic  ev_zomb
);
  always_comb begin
    post    = 1'b0;
    update  = 1'b0;
    respond = 1'b0;
    stall   = 1'b0;
    ev_wb   = 1'b0;
    ev_miss = 1'b0;
    ev_zomb = 1'b0;
    if (req) begin
      if (state == SLOT_ZOMBIE) begin
        stall   = 1'b1;
        ev_zomb = 1'b1;
      end else if (cacheable && state == SLOT_COH) begin
        respond = 1'b1;
        post    = 1'b1;
        update  = 1'b1;
      end else if (cacheable && state == SLOT_NONCOH) begin
        respond = 1'b1;
        update  = 1'b1;
        ev_wb   = 1'b1;
      end else begin
        respond = 1'b1;
        post    = 1'b1;
        ev_miss = cacheable;
      end
    end
  end
endmodule

// File: rtl/wd_line_state.sv
module wd_line_state
  import wd_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WORDS = 8,
  localparam int WAY_W  = (WAYS  > 1) ? $clog2(WAYS)  : 1,
  localparam int SET_W  = (SETS  > 1) ? $clog2(SETS)  : 1,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              set_dirty,
  input  logic              evict_valid,
  input  logic [WAY_W-1:0]  evict_way,
  input  logic [SET_W-1:0]  evict_set,
  input  logic              ack_valid,
  input  logic [WAY_W-1:0]  ack_way,
  input  logic [SET_W-1:0]  ack_set,
  output logic              line_dirty,
  output logic              word_dirty,
  output logic              zombie_ncc
);
  localparam int LINES  = WAYS * SETS;
  localparam int BITS   = LINES * WORDS;
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int BIT_W  = (BITS > 1) ? $clog2(BITS) : 1;

  logic [LINES-1:0] line_q, line_d, flag_q, flag_d;
  logic [BITS-1:0]  word_q, word_d;

  logic [LINE_W-1:0] w_line, e_line, a_line;
  logic [BIT_W-1:0]  w_bit;

  assign w_line = LINE_W'(line_index(int'(wr_way), int'(wr_set), SETS));
  assign e_line = LINE_W'(line_index(int'(evict_way), int'(evict_set), SETS));
  assign a_line = LINE_W'(line_index(int'(ack_way), int'(ack_set), SETS));
  assign w_bit  = BIT_W'(bit_index(int'(w_line), int'(wr_word), WORDS));

  always_comb begin
    line_d = line_q;
    word_d = word_q;
    flag_d = flag_q;
    if (set_dirty) begin
      line_d[w_line] = 1'b1;
      word_d[w_bit]  = 1'b1;
    end
    if (ack_valid) flag_d[a_line] = 1'b0;
    if (evict_valid) begin
      line_d[e_line] = 1'b0;
      flag_d[e_line] = 1'b1;
      for (int w = 0; w < WORDS; w++)
        word_d[BIT_W'(bit_index(int'(e_line), w, WORDS))] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      word_q <= '0;
      flag_q <= '0;
    end else begin
      line_q <= line_d;
      word_q <= word_d;
      flag_q <= flag_d;
    end
  end

  assign line_dirty = line_q[w_line];
  assign word_dirty = word_q[w_bit];
  assign zombie_ncc = flag_q[w_line];

  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty && !(evict_valid && e_line == w_line) |=> line_q[$past(w_line)] && word_q[$past(w_bit)]); // R2
  AST_EVICT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> !line_q[$past(e_line)] && flag_q[$past(e_line)]); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !(evict_valid && e_line == a_line) |=> !flag_q[$past(a_line)]); // R7
endmodule

// File: rtl/wd_stats.sv
module wd_stats
  import wd_pkg::*;
#(
  parameter int N = EV_N
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              inc,
  output logic [N-1:0][CNT_W-1:0]   cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(inc[g]) |-> cnt[g] == $past(cnt[g]) + 1'b1); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(inc[g]) |-> $stable(cnt[g])); // R8
  end
endmodule

// File: rtl/write_dispatch.sv
module write_dispatch
  import wd_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WORDS = 8,
  localparam int WAY_W  = (WAYS  > 1) ? $clog2(WAYS)  : 1,
  localparam int SET_W  = (SETS  > 1) ? $clog2(SETS)  : 1,
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_cacheable,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [1:0]        slot_state,
  input  logic              evict_valid,
  input  logic [WAY_W-1:0]  evict_way,
  input  logic [SET_W-1:0]  evict_set,
  input  logic              ack_valid,
  input  logic [WAY_W-1:0]  ack_way,
  input  logic [SET_W-1:0]  ack_set,
  output logic              wbuf_post,
  output logic              cache_update,
  output logic              rsp_valid,
  output logic              retry,
  output logic              line_dirty,
  output logic              word_dirty,
  output logic [31:0]       cnt_write_back,
  output logic [31:0]       cnt_write_miss,
  output logic [31:0]       cnt_zombie,
  output logic [31:0]       cnt_zombie_ncc
);
  logic ack_same;
  slot_e eff_state;
  logic ev_wb, ev_miss, ev_zomb, zombie_ncc;
  logic [EV_N-1:0] inc;
  logic [EV_N-1:0][CNT_W-1:0] cnt_all;

  // Acknowledge is applied before the write is judged.
  assign ack_same  = ack_valid && ack_way == wr_way && ack_set == wr_set;
  assign eff_state = ack_same ? SLOT_EMPTY : slot_e'(slot_state);

  wd_decide u_decide (
    .req       (wr_valid),
    .cacheable (wr_cacheable),
    .state     (eff_state),
    .post      (wbuf_post),
    .update    (cache_update),
    .respond   (rsp_valid),
    .stall     (retry),
    .ev_wb     (ev_wb),
    .ev_miss   (ev_miss),
    .ev_zomb   (ev_zomb)
  );

  wd_line_state #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)) u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_way      (wr_way),
    .wr_set      (wr_set),
    .wr_word     (wr_word),
    .set_dirty   (ev_wb),
    .evict_valid (evict_valid),
    .evict_way   (evict_way),
    .evict_set   (evict_set),
    .ack_valid   (ack_valid),
    .ack_way     (ack_way),
    .ack_set     (ack_set),
    .line_dirty  (line_dirty),
    .word_dirty  (word_dirty),
    .zombie_ncc  (zombie_ncc)
  );

  always_comb begin
    inc          = '0;
    inc[EV_WB]   = ev_wb;
    inc[EV_MISS] = ev_miss;
    inc[EV_ZOMB] = ev_zomb;
    inc[EV_ZNCC] = ev_zomb && zombie_ncc;
  end

  wd_stats #(.N(EV_N)) u_stats (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc),
    .cnt   (cnt_all)
  );

  assign cnt_write_back = cnt_all[EV_WB];
  assign cnt_write_miss = cnt_all[EV_MISS];
  assign cnt_zombie     = cnt_all[EV_ZOMB];
  assign cnt_zombie_ncc = cnt_all[EV_ZNCC];

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $countones({rsp_valid, retry}) == 1); // R3
  AST_STALL_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !wbuf_post && !cache_update); // R3
  AST_PULSE_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (wbuf_post || cache_update) |-> rsp_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !rsp_valid && !retry); // R8
  AST_ACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && ack_same |-> rsp_valid && wbuf_post && !cache_update); // R7
  AST_ZNCC_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zombie_ncc != $past(cnt_zombie_ncc) |-> cnt_zombie != $past(cnt_zombie)); // R4
endmodule

// File: tb/sim_write_dispatch.sv
module sim_write_dispatch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, wr_cacheable = 0;
  logic [1:0] wr_way = 0;
  logic [3:0] wr_set = 0;
  logic [2:0] wr_word = 0;
  logic [1:0] slot_state = 0;
  logic evict_valid = 0, ack_valid = 0;
  logic [1:0] evict_way = 0, ack_way = 0;
  logic [3:0] evict_set = 0, ack_set = 0;
  logic wbuf_post, cache_update, rsp_valid, retry, line_dirty, word_dirty;
  logic [31:0] cnt_write_back, cnt_write_miss, cnt_zombie, cnt_zombie_ncc;

  int checks = 0, failures = 0;
  int e_wb = 0, e_miss = 0, e_z = 0, e_zn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  write_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cacheable(wr_cacheable),
    .wr_way(wr_way), .wr_set(wr_set), .wr_word(wr_word), .slot_state(slot_state),
    .evict_valid(evict_valid), .evict_way(evict_way), .evict_set(evict_set),
    .ack_valid(ack_valid), .ack_way(ack_way), .ack_set(ack_set),
    .wbuf_post(wbuf_post), .cache_update(cache_update), .rsp_valid(rsp_valid),
    .retry(retry), .line_dirty(line_dirty), .word_dirty(word_dirty),
    .cnt_write_back(cnt_write_back), .cnt_write_miss(cnt_write_miss),
    .cnt_zombie(cnt_zombie), .cnt_zombie_ncc(cnt_zombie_ncc)
  );

  // {cacheable, state[1:0], rsp, wbuf, update, retry}
  localparam logic [6:0] VEC [8] = '{
    7'b0_00_1100, 7'b0_01_1100, 7'b0_10_1100, 7'b0_11_0001,
    7'b1_00_1100, 7'b1_01_1110, 7'b1_10_1010, 7'b1_11_0001
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_cnt(input string tag);
    chk({tag, " write_back"}, cnt_write_back, e_wb);
    chk({tag, " write_miss"}, cnt_write_miss, e_miss);
    chk({tag, " zombie"}, cnt_zombie, e_z);
    chk({tag, " zombie_ncc"}, cnt_zombie_ncc, e_zn);
  endtask

  task automatic set_wr(input logic v, input logic c, input int way, input int set,
                        input int word, input logic [1:0] st);
    wr_valid = v; wr_cacheable = c; wr_way = 2'(way); wr_set = 4'(set);
    wr_word = 3'(word); slot_state = st;
  endtask

  // Apply at negedge, let combinational settle, caller checks, then clock.
  task automatic present();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    #1;
    wr_valid = 0; evict_valid = 0; ack_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk_cnt("R9 reset");
    chk("R9 line_dirty", line_dirty, 0);
    chk("R9 word_dirty", word_dirty, 0);
    chk("R8 idle rsp", rsp_valid, 0);
    chk("R8 idle retry", retry, 0);

    // Table walk on way0 set0 word0
    for (int i = 0; i < 8; i++) begin
      logic [6:0] v;
      string tag;
      v = VEC[i];
      tag = (v[5:4] == 2'd3) ? "R3" : (v[6] && v[5:4] == 2'd1) ? "R1" :
            (v[6] && v[5:4] == 2'd2) ? "R2" : "R5";
      present();
      set_wr(1, v[6], 0, 0, 0, v[5:4]);
      #1;
      chk({tag, " rsp"}, rsp_valid, v[3]);
      chk({tag, " wbuf R8"}, wbuf_post, v[2]);
      chk({tag, " update R8"}, cache_update, v[1]);
      chk({tag, " retry"}, retry, v[0]);
      if (v[6] && v[5:4] == 2'd2) e_wb++;
      if (v[6] && v[5:4] == 2'd0) e_miss++;
      if (v[5:4] == 2'd3) e_z++;
      finish_cycle();
    end
    chk_cnt("R4 R5 R2 table");

    // R2 dirty at way0 set0 word0, not word1; R5 uncacheable did not dirty way0 set1
    present();
    set_wr(0, 0, 0, 0, 0, 0); #1;
    chk("R2 line dirty", line_dirty, 1);
    chk("R2 word dirty", word_dirty, 1);
    wr_word = 3'd1; #1;
    chk("R2 other word clean", word_dirty, 0);
    wr_set = 4'd1; #1;
    chk("R5 untouched line", line_dirty, 0);

    // R5 uncacheable write on non-coherent way0 set1 leaves it clean
    present();
    set_wr(1, 0, 0, 1, 2, 2'd2); #1;
    chk("R5 uncached ncc wbuf", wbuf_post, 1);
    chk("R5 uncached ncc update", cache_update, 0);
    finish_cycle();
    #1; set_wr(0, 0, 0, 1, 2, 0); #1;
    chk("R5 uncached no dirty", line_dirty, 0);
    chk_cnt("R5 uncached cnt");

    // NCC write way1 set3 word5
    present();
    set_wr(1, 1, 1, 3, 5, 2'd2); #1;
    e_wb++;
    finish_cycle();
    set_wr(0, 0, 1, 3, 5, 0); #1;
    chk("R2 w1s3 dirty", line_dirty, 1);
    chk("R2 w1s3 word5", word_dirty, 1);
    wr_way = 2'd0; #1;
    chk("R6 way0 set3 clean", line_dirty, 0);
    chk_cnt("R2 cnt");

    // R6 evict way1 set3
    present();
    evict_valid = 1; evict_way = 2'd1; evict_set = 4'd3;
    finish_cycle();
    set_wr(0, 0, 1, 3, 5, 0); #1;
    chk("R6 evicted line clean", line_dirty, 0);
    chk("R6 evicted word clean", word_dirty, 0);
    wr_way = 2'd0; wr_set = 4'd0; wr_word = 3'd0; #1;
    chk("R6 other line kept", line_dirty, 1);

    // R4 zombie write on flagged line
    present();
    set_wr(1, 1, 1, 3, 5, 2'd3); #1;
    chk("R3 zombie retry", retry, 1);
    e_z++; e_zn++;
    finish_cycle();
    chk_cnt("R4 flagged zombie");

    // R4 zombie write on unflagged line way2 set3
    present();
    set_wr(1, 1, 2, 3, 0, 2'd3); #1;
    e_z++;
    finish_cycle();
    chk_cnt("R4 unflagged zombie");

    // R7 ack on other way same set: still stalled
    present();
    set_wr(1, 1, 1, 3, 5, 2'd3);
    ack_valid = 1; ack_way = 2'd0; ack_set = 4'd3; #1;
    chk("R7 other ack retry", retry, 1);
    e_z++; e_zn++;
    finish_cycle();
    chk_cnt("R7 other ack cnt");

    // R7 ack and write on same line in the same cycle
    present();
    set_wr(1, 1, 1, 3, 5, 2'd3);
    ack_valid = 1; ack_way = 2'd1; ack_set = 4'd3; #1;
    chk("R7 same ack rsp", rsp_valid, 1);
    chk("R7 same ack wbuf", wbuf_post, 1);
    chk("R7 same ack update", cache_update, 0);
    chk("R7 same ack retry", retry, 0);
    e_miss++;
    finish_cycle();
    chk_cnt("R7 same ack cnt");

    // R7 flag cleared: zombie write no longer counts as non-coherent
    present();
    set_wr(1, 1, 1, 3, 5, 2'd3); #1;
    e_z++;
    finish_cycle();
    chk_cnt("R7 flag cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule